// File: doc/BRIEF.md
# Two-Class Credit-Based Egress Shaper

This block paces the two most urgent traffic classes of an egress port. Each shaped class keeps a signed credit counter. Credit grows while the class has a frame queued and its transmission gate is open. Credit shrinks while the class is on the wire. The class may begin a new frame only when its credit is zero or more. Each class is given a bandwidth share, a whole percentage of the port rate, and an upper credit limit. The limit is expressed in the same clock-scaled units as the counter.

Software configures the two classes through a single write strobe that carries a traffic-class number. The block enforces the rules on its own and refuses any write that breaks them. Only the two highest class numbers can be shaped. The upper class must be switched on before the lower one, and switched off after it. The two shares together must stay under 100 %. The port link rate is taken in as a raw code and turned into a speed code and a per-cycle rate multiplier. The MAC uses the per-class eligible outputs to decide when a queued frame of that class may start.

Top module: `cbs_two_class_shaper`

## Requirements
- R1: A write whose class number is neither NUM_TC-1 (slot 0, the top class) nor NUM_TC-2 (slot 1, the second class) is refused. cfg_rej pulses for one cycle after the write edge, and no stored setting changes.
- R2: An accepted write pulses cfg_ok for one cycle after the write edge. cfg_ok and cfg_rej are never high together.
- R3: Enabling slot 1 is refused unless slot 0 is already enabled. Disabling slot 0 is refused while slot 1 is enabled. Disabling slot 1 is always accepted.
- R4: An enabling write is refused when its share plus the share of the other slot (counted only if that slot is enabled) is 100 or more.
- R5: For an enabled slot that is not sending and has a frame pending, credit rises by share×M per cycle while gate_open is 1, and holds while gate_open is 0. M is the rate multiplier.
- R6: For an enabled slot, each cycle with q_sending high lowers credit by (100−share)×M. Sending takes precedence over accrual.
- R7: Credit never exceeds the programmed hiCredit value of its slot.
- R8: With nothing pending and nothing sending, positive credit is cleared to zero in one cycle. Negative credit rises by share×M per cycle but stops at zero.
- R9: A disabled slot holds zero credit and drives tx_eligible high, whether or not it is sending. A disable takes effect on the cycle after its write edge.
- R10: link_rate raw value 2, 3 and 4 map to speed_code 1 (100M, M=10), 2 (1000M, M=100) and 3 (2500M, M=250). Every other raw value maps to speed_code 0 (10M, M=1). speed_code updates one edge after link_rate, and M is applied to credit on the edge after that.
- R11: tx_eligible is a register that is high when the slot's credit after the same edge is ≥ 0. After reset both slots are disabled, tx_eligible is 2'b11, cfg_ok and cfg_rej are 0, and speed_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_rate | input | 3 | Raw port link-rate code |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_tc | input | TC_W | Traffic-class number of the write |
| cfg_en | input | 1 | Enable (1) or disable (0) shaping for that class |
| cfg_bw | input | BW_W | Bandwidth share in percent |
| cfg_hicredit | input | HC_W | Credit upper limit in clock-scaled units |
| cfg_ok | output | 1 | Write accepted pulse |
| cfg_rej | output | 1 | Write refused pulse |
| q_pending | input | 2 | Per-slot frame waiting |
| q_sending | input | 2 | Per-slot transmission in progress |
| gate_open | input | 2 | Per-slot transmission gate open |
| tx_eligible | output | 2 | Per-slot permission to start a frame |
| speed_code | output | 2 | Encoded port speed |

## Verification
Two functions collide in the same cycle. One is a configuration write that turns off shaping for a class. The other is that class's own credit update while it is transmitting. The bench provokes this by driving slot 0 deep into negative credit. It then keeps q_sending high and issues the disable on that same cycle. The edge that stores the disable still charges the frame, so the slot stays ineligible. On the following edge the disable must win: credit must be cleared and tx_eligible must rise, even though q_sending is still high.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int MULT_W = 8;

  typedef enum logic [1:0] {
    SPD_10M  = 2'd0,
    SPD_100M = 2'd1,
    SPD_1G   = 2'd2,
    SPD_2G5  = 2'd3
  } spd_e;

  function automatic spd_e map_link(input logic [2:0] raw);
    case (raw)
      3'd2:    return SPD_100M;
      3'd3:    return SPD_1G;
      3'd4:    return SPD_2G5;
      default: return SPD_10M;
    endcase
  endfunction

  function automatic logic [MULT_W-1:0] spd_mult(input spd_e c);
    case (c)
      SPD_100M: return MULT_W'(10);
      SPD_1G:   return MULT_W'(100);
      SPD_2G5:  return MULT_W'(250);
      default:  return MULT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/cbs_rate_map.sv
module cbs_rate_map
  import cbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        link_rate,
  output logic [1:0]        code,
  output logic [MULT_W-1:0] mult
);
  spd_e code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= SPD_10M;
      mult   <= MULT_W'(1);
    end else begin
      code_q <= map_link(link_rate);
      mult   <= spd_mult(map_link(link_rate));
    end
  end

  assign code = code_q;

  p_unknown_rate_r10: assert property (@(posedge clk) disable iff (rst)
    !(link_rate inside {3'd2, 3'd3, 3'd4}) |=> code == 2'd0);
endmodule

// File: rtl/cbs_cfg_regs.sv
module cbs_cfg_regs #(
  parameter int NUM_TC = 8,
  parameter int TC_W   = 3,
  parameter int BW_W   = 7,
  parameter int HC_W   = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [TC_W-1:0]      cfg_tc,
  input  logic                 cfg_en,
  input  logic [BW_W-1:0]      cfg_bw,
  input  logic [HC_W-1:0]      cfg_hicredit,
  output logic                 cfg_ok,
  output logic                 cfg_rej,
  output logic [1:0]           en_q,
  output logic [1:0][BW_W-1:0] bw_q,
  output logic [1:0][HC_W-1:0] hc_q
);
  localparam logic [TC_W-1:0] TOP_TC = TC_W'(NUM_TC - 1);
  localparam logic [TC_W-1:0] SEC_TC = TC_W'(NUM_TC - 2);
  localparam logic [BW_W:0]   LIMIT  = (BW_W+1)'(100);

  logic          is_top, is_sec, slot, other, sum_ok, accept;
  logic [BW_W:0] share_sum;

  always_comb begin
    is_top    = (cfg_tc == TOP_TC);
    is_sec    = (cfg_tc == SEC_TC);
    slot      = is_sec;
    other     = ~slot;
    share_sum = {1'b0, cfg_bw} + (en_q[other] ? {1'b0, bw_q[other]} : '0);
    sum_ok    = (share_sum < LIMIT);
    if (!(is_top || is_sec))
      accept = 1'b0;
    else if (cfg_en)
      accept = sum_ok && (is_top || en_q[0]);
    else
      accept = is_sec || !en_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ok  <= 1'b0;
      cfg_rej <= 1'b0;
      en_q    <= '0;
      bw_q    <= '0;
      hc_q    <= '0;
    end else begin
      cfg_ok  <= 1'b0;
      cfg_rej <= 1'b0;
      if (cfg_wr) begin
        if (accept) begin
          cfg_ok     <= 1'b1;
          en_q[slot] <= cfg_en;
          bw_q[slot] <= cfg_en ? cfg_bw : '0;
          hc_q[slot] <= cfg_en ? cfg_hicredit : '0;
        end else begin
          cfg_rej <= 1'b1;
        end
      end
    end
  end

  p_ok_rej_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(cfg_ok && cfg_rej));
  p_enable_order_r3: assert property (@(posedge clk) disable iff (rst)
    en_q[1] |-> en_q[0]);
  p_share_sum_r4: assert property (@(posedge clk) disable iff (rst)
    (&en_q) |-> ({1'b0, bw_q[0]} + {1'b0, bw_q[1]} < LIMIT));
  p_foreign_tc_r1: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_tc != TOP_TC && cfg_tc != SEC_TC) |=> (cfg_rej && $stable(en_q)));
endmodule

// File: rtl/cbs_credit_acc.sv
module cbs_credit_acc
  import cbs_pkg::*;
#(
  parameter int CW   = 24,
  parameter int BW_W = 7,
  parameter int HC_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [BW_W-1:0]   bw,
  input  logic [HC_W-1:0]   hicredit,
  input  logic [MULT_W-1:0] mult,
  input  logic              pending,
  input  logic              sending,
  input  logic              gate,
  output logic              eligible
);
  localparam int PW = BW_W + MULT_W;
  localparam logic [BW_W-1:0]  HUNDRED = BW_W'(100);
  localparam logic signed [CW:0] FLOOR = {2'b11, {(CW-1){1'b0}}};

  logic signed [CW-1:0] credit;
  logic signed [CW:0]   cur, idle_s, send_s, cap_s, nxt;
  logic [PW-1:0]        idle_u, send_u;

  always_comb begin
    idle_u = PW'(bw) * PW'(mult);
    send_u = PW'(HUNDRED - bw) * PW'(mult);
    idle_s = $signed({{(CW+1-PW){1'b0}}, idle_u});
    send_s = $signed({{(CW+1-PW){1'b0}}, send_u});
    cap_s  = $signed({{(CW+1-HC_W){1'b0}}, hicredit});
    cur    = {credit[CW-1], credit};
    if (sending) begin
      nxt = cur - send_s;
      if (nxt < FLOOR) nxt = FLOOR;
    end else if (pending) begin
      nxt = gate ? cur + idle_s : cur;
    end else if (!cur[CW] && cur != '0) begin
      nxt = '0;
    end else begin
      nxt = cur + idle_s;
      if (!nxt[CW]) nxt = '0;
    end
    if (nxt > cap_s) nxt = cap_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      credit   <= '0;
      eligible <= 1'b1;
    end else begin
      credit   <= nxt[CW-1:0];
      eligible <= !nxt[CW];
    end
  end

  p_credit_cap_r7: assert property (@(posedge clk) disable iff (rst)
    en |=> (cur <= $past(cap_s)));
  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (credit == '0 && eligible));
  p_empty_queue_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !pending && !sending) |=> (cur[CW] || cur == '0));
  p_send_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && sending && bw < HUNDRED) |=> (cur < $past(cur) || cur == FLOOR));
endmodule

// File: rtl/cbs_two_class_shaper.sv
module cbs_two_class_shaper
  import cbs_pkg::*;
#(
  parameter int NUM_TC = 8,
  parameter int TC_W   = $clog2(NUM_TC),
  parameter int BW_W   = 7,
  parameter int HC_W   = 20,
  parameter int CW     = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      link_rate,
  input  logic            cfg_wr,
  input  logic [TC_W-1:0] cfg_tc,
  input  logic            cfg_en,
  input  logic [BW_W-1:0] cfg_bw,
  input  logic [HC_W-1:0] cfg_hicredit,
  output logic            cfg_ok,
  output logic            cfg_rej,
  input  logic [1:0]      q_pending,
  input  logic [1:0]      q_sending,
  input  logic [1:0]      gate_open,
  output logic [1:0]      tx_eligible,
  output logic [1:0]      speed_code
);
  localparam int SLOTS = 2;

  logic [MULT_W-1:0]         mult;
  logic [SLOTS-1:0]          en_q;
  logic [SLOTS-1:0][BW_W-1:0] bw_q;
  logic [SLOTS-1:0][HC_W-1:0] hc_q;

  cbs_rate_map u_rate (
    .clk(clk), .rst(rst), .link_rate(link_rate),
    .code(speed_code), .mult(mult)
  );

  cbs_cfg_regs #(
    .NUM_TC(NUM_TC), .TC_W(TC_W), .BW_W(BW_W), .HC_W(HC_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_tc(cfg_tc),
    .cfg_en(cfg_en), .cfg_bw(cfg_bw), .cfg_hicredit(cfg_hicredit),
    .cfg_ok(cfg_ok), .cfg_rej(cfg_rej),
    .en_q(en_q), .bw_q(bw_q), .hc_q(hc_q)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    cbs_credit_acc #(.CW(CW), .BW_W(BW_W), .HC_W(HC_W)) u_acc (
      .clk(clk), .rst(rst), .en(en_q[s]), .bw(bw_q[s]),
      .hicredit(hc_q[s]), .mult(mult),
      .pending(q_pending[s]), .sending(q_sending[s]), .gate(gate_open[s]),
      .eligible(tx_eligible[s])
    );
  end
endmodule

// File: tb/test_cbs_two_class_shaper.sv
`timescale 1ns/1ps
module test_cbs_two_class_shaper;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  link_rate;
  logic        cfg_wr, cfg_en, cfg_ok, cfg_rej;
  logic [2:0]  cfg_tc;
  logic [6:0]  cfg_bw;
  logic [19:0] cfg_hicredit;
  logic [1:0]  q_pending, q_sending, gate_open, tx_eligible, speed_code;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  cbs_two_class_shaper i_cbs_two_class_shaper (
    .clk(clk), .rst(rst), .link_rate(link_rate),
    .cfg_wr(cfg_wr), .cfg_tc(cfg_tc), .cfg_en(cfg_en), .cfg_bw(cfg_bw),
    .cfg_hicredit(cfg_hicredit), .cfg_ok(cfg_ok), .cfg_rej(cfg_rej),
    .q_pending(q_pending), .q_sending(q_sending), .gate_open(gate_open),
    .tx_eligible(tx_eligible), .speed_code(speed_code)
  );

  typedef struct packed {
    logic [2:0]  tc;
    logic        en;
    logic [6:0]  bw;
    logic [19:0] hc;
    logic        ok;
  } cfg_vec_t;

  localparam int NV = 9;
  localparam cfg_vec_t TBL [NV] = '{
    '{3'd3, 1'b1, 7'd10,  20'd50,   1'b0},  // R1 foreign class
    '{3'd6, 1'b1, 7'd20,  20'd50,   1'b0},  // R3 second before top
    '{3'd7, 1'b1, 7'd100, 20'd50,   1'b0},  // R4 share reaches 100
    '{3'd7, 1'b1, 7'd60,  20'd1000, 1'b1},  // R2 top on
    '{3'd6, 1'b1, 7'd40,  20'd500,  1'b0},  // R4 60+40
    '{3'd6, 1'b1, 7'd30,  20'd500,  1'b1},  // R3 second on
    '{3'd7, 1'b0, 7'd0,   20'd0,    1'b0},  // R3 top off too early
    '{3'd6, 1'b0, 7'd0,   20'd0,    1'b1},  // R3 second off
    '{3'd7, 1'b0, 7'd0,   20'd0,    1'b1}   // R3 top off
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [2:0] tc, input logic en,
                           input logic [6:0] bw, input logic [19:0] hc);
    cfg_wr = 1'b1; cfg_tc = tc; cfg_en = en; cfg_bw = bw; cfg_hicredit = hc;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; link_rate = 3'd1; cfg_wr = 1'b0; cfg_tc = '0; cfg_en = 1'b0;
    cfg_bw = '0; cfg_hicredit = '0; q_pending = '0; q_sending = '0; gate_open = '0;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R11 reset eligible", tx_eligible, 3);
    chk("R11 reset ok", cfg_ok, 0);
    chk("R11 reset rej", cfg_rej, 0);
    chk("R11 reset speed", speed_code, 0);

    for (int i = 0; i < NV; i++) begin
      write_cfg(TBL[i].tc, TBL[i].en, TBL[i].bw, TBL[i].hc);
      chk($sformatf("R2 ok vec%0d", i), cfg_ok, TBL[i].ok);
      chk($sformatf("R1 rej vec%0d", i), cfg_rej, !TBL[i].ok);
    end

    // top slot: share 60, hiCredit 100, M=1
    write_cfg(3'd7, 1'b1, 7'd60, 20'd100);
    chk("R2 top enable", cfg_ok, 1);
    q_pending = 2'b11; gate_open = 2'b01;
    step(5);                                   // 60,100(cap)
    chk("R5 accrue eligible", tx_eligible[0], 1);
    q_sending = 2'b11;
    step(2);                                   // 60,20
    chk("R6 after two sends", tx_eligible[0], 1);
    chk("R9 disabled slot sends", tx_eligible[1], 1);
    step(1);                                   // -20
    chk("R7 cap then negative", tx_eligible[0], 0);
    q_sending = 2'b00; gate_open = 2'b00;
    step(3);                                   // hold -20
    chk("R5 gate closed holds", tx_eligible[0], 0);
    gate_open = 2'b01;
    step(1);                                   // 40
    chk("R5 gate open accrues", tx_eligible[0], 1);
    step(4);                                   // 100
    q_pending = 2'b00;
    step(1);                                   // cleared to 0
    q_pending = 2'b01; gate_open = 2'b00; q_sending = 2'b01;
    step(1);                                   // -40
    chk("R8 positive credit cleared", tx_eligible[0], 0);
    q_sending = 2'b00; q_pending = 2'b00;
    step(1);                                   // -40+60 -> 0
    chk("R8 negative recovers", tx_eligible[0], 1);

    link_rate = 3'd2;
    step(1);
    chk("R10 speed 100M", speed_code, 1);
    step(1);
    q_pending = 2'b01; gate_open = 2'b01;
    step(1);                                   // +600 -> cap 100
    q_sending = 2'b01; gate_open = 2'b00;
    step(1);                                   // 100-400 = -300
    chk("R10 multiplier applied", tx_eligible[0], 0);
    q_sending = 2'b00; q_pending = 2'b00;
    step(1);                                   // -300+600 -> 0
    chk("R11 eligible at zero", tx_eligible[0], 1);
    link_rate = 3'd6;
    step(1);
    chk("R10 unknown maps 10M", speed_code, 0);
    link_rate = 3'd4;
    step(1);
    chk("R10 speed 2500M", speed_code, 3);

    // disable arrives while the slot is sending with negative credit
    q_pending = 2'b01; q_sending = 2'b01;
    step(1);
    chk("R6 deep negative", tx_eligible[0], 0);
    write_cfg(3'd7, 1'b0, 7'd0, 20'd0);
    chk("R3 top off accepted", cfg_ok, 1);
    chk("R9 disable not yet applied", tx_eligible[0], 0);
    step(1);
    chk("R9 disable wins over send", tx_eligible[0], 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule